// File: doc/BRIEF.md
# Least-Recently-Granted Bus Arbiter

This block decides which of five masters may drive a shared bus: the local host controller, whose request and grant are internal active-high signals, and four external devices, each with an active-low request input and an active-low grant output. It holds an ordered list of all five masters. Whenever a granted master finishes its transfer, signalled by a one-cycle done strobe, that master is taken out of its place in the list and appended at the tail. The masters it passed over keep their relative order, so the list always ranks masters by how long ago each was last served.

With no master requesting, the bus is parked on the host. A mode input says whether the controller is the bus host. When it is low the arbiter stands aside: it drives no grant and its list stays frozen until host mode returns. Grants are registered. A grant stays on until its owner strobes done, and an idle cycle with no grant always follows a completed transfer.

Top module: `lrg_arbiter`

## Requirements
- R1: While reset is held, no grant is asserted. The list after reset ranks the host first, then devices 1, 2, 3 and 4 in that order.
- R2: Bit i of `dev_req_n` and `dev_gnt_n` belongs to device i+1, and both are active low. A device whose request input stays high is never granted.
- R3: When the arbiter is free and masters are requesting, the grant goes to the requesting master that sits highest in the list, one clock edge after the decision.
- R4: At most one of the five grants is active in any cycle.
- R5: A granted master keeps its grant, whatever other requests do, until it pulses `done`.
- R6: A `done` pulse during a granted transfer moves the owner to the tail of the list, and all other masters keep their relative order. For example, host>1>2>3>4 becomes host>2>3>4>1 after device 1 finishes, and 2>3>4>1>host becomes 2>4>1>host>3 after device 3 finishes.
- R7: In the cycle after a `done` pulse that ends a granted transfer, no grant is asserted.
- R8: In host mode, one idle cycle with no request leads to the host being parked (`host_gnt` high). A device request removes the parking grant, and the device is granted after one idle cycle. A host request while parked turns the parking grant into a transfer grant with no gap.
- R9: A `done` pulse while the bus is only parked leaves the list unchanged.
- R10: With `host_mode` low, all grants are deasserted in that same cycle. Requests and `done` are ignored, and the list keeps its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_mode | input | 1 | 1: controller is bus host, arbiter enabled; 0: arbiter disabled |
| host_req | input | 1 | Host bus request, active high |
| host_gnt | output | 1 | Host grant, active high (also marks parking) |
| dev_req_n | input | NUM_DEV | External device requests, active low, bit i = device i+1 |
| dev_gnt_n | output | NUM_DEV | External device grants, active low, bit i = device i+1 |
| done | input | 1 | One-cycle strobe from the granted master ending its transfer |

## Verification
The list cannot be read directly. A corrupted list shows only as a wrong winner order the next time several masters compete, so each reordering is followed by a round in which every master requests, and the order of the grants is checked against a model list kept in the bench. A fault in the grant state machine shows within one or two cycles: a missing idle cycle after done, a grant dropped early, a parking grant that lingers, or a grant left on after host mode falls. These are sampled at the cycle where each one must appear.

// File: rtl/lrg_arb_pkg.sv
// Package: shared types for the least-recently-granted arbiter.
// Assumes: nothing beyond standard SystemVerilog.
package lrg_arb_pkg;

    // Grant controller state: free, parked on host, or a transfer in progress.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PARK = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_t;

endpackage

// File: rtl/lrg_prio_list.sv
// Module: lrg_prio_list
// Holds the full priority list of NM master ids. Position 0 is the highest
// priority. On upd_en the entry equal to upd_id is removed, the entries
// behind it move up one place, and upd_id is written into the last position.
// Assumes: upd_id is always present in the list exactly once.
module lrg_prio_list #(
    parameter int NM  = 5,
    parameter int IDW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_en,
    input  logic [IDW-1:0]           upd_id,
    output logic [NM-1:0][IDW-1:0]   order
);

    logic [NM-1:0][IDW-1:0] order_q;
    logic [NM-1:0][IDW-1:0] order_d;

    // Build the list with upd_id removed and appended at the tail.
    always_comb begin
        logic passed;
        passed  = 1'b0;
        order_d = order_q;
        for (int k = 0; k < NM; k++) begin
            if (order_q[k] == upd_id) begin
                passed = 1'b1;
            end
            if (passed && (k < NM - 1)) begin
                order_d[k] = order_q[k+1];
            end
        end
        if (passed) begin
            order_d[NM-1] = upd_id;
        end
    end

    // List register: id order at reset, reordered on each completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NM; k++) begin
                order_q[k] <= IDW'(k);
            end
        end else if (upd_en) begin
            order_q <= order_d;
        end
    end

    assign order = order_q;

endmodule

// File: rtl/lrg_pick.sv
// Module: lrg_pick
// Combinational winner search: walks the priority list and returns the
// first id whose request bit is set.
// Assumes: every list entry is a valid index into req.
module lrg_pick #(
    parameter int NM  = 5,
    parameter int IDW = 3
) (
    input  logic [NM-1:0]            req,
    input  logic [NM-1:0][IDW-1:0]   order,
    output logic [IDW-1:0]           win_id,
    output logic                     win_vld
);

    // Scan from lowest to highest priority so the top requester is kept.
    always_comb begin
        win_id  = '0;
        win_vld = 1'b0;
        for (int k = NM - 1; k >= 0; k--) begin
            if (req[order[k]]) begin
                win_id  = order[k];
                win_vld = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lrg_grant_ctl.sv
// Module: lrg_grant_ctl
// Grant state machine. From IDLE it grants the search winner or parks on
// the host (id 0). A transfer grant is held until done, then IDLE follows
// for one cycle. The parking grant turns into a transfer grant if the host
// wins, or falls to IDLE if a device wins. host_mode low forces IDLE and
// masks every grant in the same cycle.
// Assumes: id 0 is the host.
module lrg_grant_ctl
    import lrg_arb_pkg::*;
#(
    parameter int NM  = 5,
    parameter int IDW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_mode,
    input  logic [IDW-1:0]  win_id,
    input  logic            win_vld,
    input  logic            done,
    output logic [IDW-1:0]  owner_id,
    output logic [NM-1:0]   gnt_vec,
    output logic            busy,
    output logic            upd_en
);

    arb_state_t     state_q, state_d;
    logic [IDW-1:0] owner_q, owner_d;

    // Next-state and next-owner decision.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        if (!host_mode) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (win_vld) begin
                        state_d = ST_BUSY;
                        owner_d = win_id;
                    end else begin
                        state_d = ST_PARK;
                        owner_d = '0;
                    end
                end
                ST_PARK: begin
                    if (win_vld && (win_id == '0)) begin
                        state_d = ST_BUSY;
                        owner_d = '0;
                    end else if (win_vld) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_BUSY: begin
                    if (done) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // One grant line per master, decoded from the owner and masked by mode.
    for (genvar i = 0; i < NM; i++) begin : g_gnt
        assign gnt_vec[i] = host_mode && (state_q != ST_IDLE) &&
                            (owner_q == IDW'(i));
    end

    assign busy     = (state_q == ST_BUSY);
    assign upd_en   = host_mode && busy && done;
    assign owner_id = owner_q;

endmodule

// File: rtl/lrg_arbiter.sv
// Module: lrg_arbiter (top)
// Least-recently-granted arbiter for a host and NUM_DEV external masters.
// Maps the pins to an active-high request vector (id 0 = host, id i =
// device i), runs the winner search over the priority list, and drives
// registered grants from the grant state machine.
// Assumes: done is a one-cycle strobe issued by the current grant owner.
module lrg_arbiter #(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_mode,
    input  logic               host_req,
    output logic               host_gnt,
    input  logic [NUM_DEV-1:0] dev_req_n,
    output logic [NUM_DEV-1:0] dev_gnt_n,
    input  logic               done
);

    localparam int NM  = NUM_DEV + 1;
    localparam int IDW = $clog2(NM);

    logic [NM-1:0]          req_vec;
    logic [NM-1:0][IDW-1:0] order;
    logic [IDW-1:0]         win_id;
    logic                   win_vld;
    logic [IDW-1:0]         owner_id;
    logic [NM-1:0]          gnt_vec;
    logic                   ctl_busy;
    logic                   upd_en;

    // Active-high request vector: host at bit 0, devices above it.
    assign req_vec = {~dev_req_n, host_req};

    lrg_prio_list #(.NM(NM), .IDW(IDW)) u_list (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (upd_en),
        .upd_id (owner_id),
        .order  (order)
    );

    lrg_pick #(.NM(NM), .IDW(IDW)) u_pick (
        .req     (req_vec),
        .order   (order),
        .win_id  (win_id),
        .win_vld (win_vld)
    );

    lrg_grant_ctl #(.NM(NM), .IDW(IDW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_mode (host_mode),
        .win_id    (win_id),
        .win_vld   (win_vld),
        .done      (done),
        .owner_id  (owner_id),
        .gnt_vec   (gnt_vec),
        .busy      (ctl_busy),
        .upd_en    (upd_en)
    );

    assign host_gnt  = gnt_vec[0];
    assign dev_gnt_n = ~gnt_vec[NM-1:1];

endmodule

// File: rtl/lrg_arb_chk.sv
// Module: lrg_arb_chk
// Assertion checker bound into lrg_arbiter. It watches the pins and the
// controller's busy flag.
// Assumes: reset is applied from time zero.
module lrg_arb_chk #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_mode,
    input logic               host_req,
    input logic               host_gnt,
    input logic [NUM_DEV-1:0] dev_req_n,
    input logic [NUM_DEV-1:0] dev_gnt_n,
    input logic               done,
    input logic               busy
);

    logic [NUM_DEV:0] gnts;
    assign gnts = {~dev_gnt_n, host_gnt};

    logic no_req;
    assign no_req = !host_req && (&dev_req_n);

    // R4: never two grants at once.
    p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnts));

    // R10: disabled mode shows no grant.
    p_nonhost_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> (gnts == '0));

    // R7: the cycle after a finished transfer carries no grant.
    p_gap_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (gnts == '0));

    // R5: a transfer grant is held until done (unless mode drops).
    p_hold_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && host_mode) |=> (!host_mode || $stable(gnts)));

    // R8: in host mode, a free cycle with no request leads to parking.
    p_park_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && !busy && no_req) |=> (!host_mode || host_gnt));

    // R2: a device grant only rises after that device requested.
    p_dev_gnt_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~dev_gnt_n & $past(dev_gnt_n))) |->
            (((~dev_gnt_n) & $past(dev_req_n)) == '0));

endmodule

bind lrg_arbiter lrg_arb_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_mode (host_mode),
    .host_req  (host_req),
    .host_gnt  (host_gnt),
    .dev_req_n (dev_req_n),
    .dev_gnt_n (dev_gnt_n),
    .done      (done),
    .busy      (ctl_busy)
);

// File: tb/lrg_arbiter_bench.sv
module lrg_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b1;
    logic       host_req = 1'b0;
    logic       host_gnt;
    logic [3:0] dev_req_n = 4'hF;
    logic [3:0] dev_gnt_n;
    logic       done = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int model [5];

    always #5 clk = ~clk;

    lrg_arbiter #(.NUM_DEV(4)) u_lrg_arbiter (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .host_req(host_req),
        .host_gnt(host_gnt), .dev_req_n(dev_req_n), .dev_gnt_n(dev_gnt_n),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // -1 no grant, -2 several grants, else the granted id (0 = host).
    function automatic int gnt_id();
        int n = 0;
        int id = -1;
        if (host_gnt) begin n++; id = 0; end
        for (int i = 0; i < 4; i++) if (!dev_gnt_n[i]) begin n++; id = i + 1; end
        return (n > 1) ? -2 : id;
    endfunction

    function automatic void move_to_tail(input int id);
        int p = 0;
        for (int k = 0; k < 5; k++) if (model[k] == id) p = k;
        for (int k = p; k < 4; k++) model[k] = model[k+1];
        model[4] = id;
    endfunction

    task automatic set_req(input logic [4:0] mask);
        host_req  = mask[0];
        dev_req_n = ~mask[4:1];
    endtask

    // Serve every master in mask, checking order, hold and idle gap.
    task automatic serve_round(input logic [4:0] mask, input string tag);
        logic [4:0] m = mask;
        @(negedge clk);
        set_req(m);
        while (m != 0) begin
            int exp = -1;
            int g = -1;
            for (int k = 4; k >= 0; k--) if (m[model[k]]) exp = model[k];
            for (int t = 0; t < 10; t++) begin
                @(negedge clk);
                g = gnt_id();
                if (g >= 0 && !(g == 0 && !m[0])) break;
            end
            check(g == exp, {tag, " R3/R6 winner"}, g, exp);
            check(g != -2, "R4 single grant", g, exp);
            @(negedge clk);
            check(gnt_id() == exp, "R5 grant held", gnt_id(), exp);
            done = 1'b1;
            if (exp >= 0) m[exp] = 1'b0;
            set_req(m);
            @(negedge clk);
            done = 1'b0;
            check(gnt_id() == -1, "R7 idle after done", gnt_id(), -1);
            if (exp >= 0) move_to_tail(exp);
            else m = 0;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(gnt_id() == -1, "R1 no grant in reset", gnt_id(), -1);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_gnt == 1'b1, "R8 park after reset", host_gnt, 1);
        check(dev_gnt_n == 4'hF, "R1 device grants off", dev_gnt_n, 15);
    endtask

    task automatic t_reorder();
        // Walks the worked examples, then an all-request round checks the list.
        serve_round(5'b00010, "R6 dev1");
        serve_round(5'b00001, "R6 host");
        serve_round(5'b01000, "R6 dev3");
        check(model[0] == 2 && model[1] == 4 && model[2] == 1 && model[3] == 0,
              "R6 model order", model[1], 4);
        serve_round(5'b11111, "R6 all");
    endtask

    task automatic t_unused();
        // Device 4 input high: never granted, bus parks afterwards.
        serve_round(5'b01111, "R2 dev4 high");
        @(negedge clk);
        check(dev_gnt_n[3] == 1'b1, "R2 dev4 not granted", dev_gnt_n[3], 1);
        check(host_gnt == 1'b1, "R8 parked", host_gnt, 1);
    endtask

    task automatic t_park();
        int id0;
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(host_gnt == 1'b1, "R9 park kept after done", host_gnt, 1);
        // Host request while parked: no gap in host_gnt.
        host_req = 1'b1;
        @(negedge clk);
        check(host_gnt == 1'b1, "R8 park to grant no gap", host_gnt, 1);
        done = 1'b1; host_req = 1'b0;
        @(negedge clk);
        done = 1'b0;
        check(gnt_id() == -1, "R7 gap after host", gnt_id(), -1);
        move_to_tail(0);
        // Device request while parked: park dropped, one idle cycle.
        repeat (2) @(negedge clk);
        id0 = gnt_id();
        check(id0 == 0, "R8 parked again", id0, 0);
        dev_req_n = 4'b1101;
        @(negedge clk);
        check(gnt_id() == -1, "R8 park released", gnt_id(), -1);
        @(negedge clk);
        check(gnt_id() == 2, "R8 device after gap", gnt_id(), 2);
        done = 1'b1; dev_req_n = 4'hF;
        @(negedge clk);
        done = 1'b0;
        move_to_tail(2);
        serve_round(5'b11111, "R9 list intact");
    endtask

    task automatic t_hold();
        @(negedge clk);
        dev_req_n = 4'b1011;
        repeat (3) @(negedge clk);
        check(gnt_id() == 3, "R5 dev3 granted", gnt_id(), 3);
        host_req = 1'b1; dev_req_n = 4'b0000;
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            check(gnt_id() == 3, "R5 held under competition", gnt_id(), 3);
        end
        done = 1'b1; set_req(5'b00000);
        @(negedge clk);
        done = 1'b0;
        move_to_tail(3);
    endtask

    task automatic t_nonhost();
        @(negedge clk);
        dev_req_n = 4'b1110;
        repeat (3) @(negedge clk);
        check(gnt_id() == 1, "R10 setup grant", gnt_id(), 1);
        host_mode = 1'b0;
        #1;
        check(gnt_id() == -1, "R10 grant drops at once", gnt_id(), -1);
        set_req(5'b11111);
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            done = (t == 1);
            check(gnt_id() == -1, "R10 no grant disabled", gnt_id(), -1);
        end
        done = 1'b0;
        set_req(5'b00000);
        host_mode = 1'b1;
        serve_round(5'b11111, "R10 list frozen");
    endtask

    initial begin
        for (int k = 0; k < 5; k++) model[k] = k;
        t_reset();
        t_reorder();
        t_unused();
        t_park();
        t_hold();
        t_nonhost();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule